// File: doc/BRIEF.md
# Paired-Link Channel Interleaver

This block lets two 32-channel serial streams, A and B, share the fiber slot of one link. When sharing is on, the transmit path takes even channels from stream A and odd channels from stream B, so each stream keeps half its channels. The receive path turns each pair of fiber bytes back into two streams. Output A repeats the even fiber byte over a channel pair, and output B repeats the odd fiber byte over the same pair. When sharing is off, stream A passes through untouched, input B is ignored and output B stays idle.

Data moves one byte per channel, with a 5-bit channel index and a valid strobe on each side. A 3-bit mode input sets both the sharing choice and controller or peripheral timing. Codes the block does not define raise a mode error and fall back to no sharing with controller timing.

In sharing mode the receive path finishes a pair on its odd-channel input. It writes the even-slot result at once and the odd-slot result on the next clock, without further input. For that reason `rx_valid` must be low in the cycle that follows an odd-channel input while sharing is on.

Top module: `chan_pair_mux`

## Requirements
- R1: Mode codes are decoded and appear on `share_on` and `periph_mode` one clock after `mode_sel` changes: 000 gives sharing with controller timing, 001 sharing with peripheral timing, 011 no sharing with controller timing, 111 no sharing with peripheral timing. For all four, `mode_err` is 0.
- R2: Codes 010, 100, 101 and 110 set `mode_err` to 1, `share_on` to 0 and `periph_mode` to 0 one clock later. The transmit and receive paths then behave as with sharing off.
- R3: With sharing on, each transmit strobe for channel k gives `tx_out_byte`, one clock later, equal to the A byte when k is even (bit 0 = 0) and the B byte when k is odd. `tx_out_chan` equals k and `tx_out_valid` is 1 in that cycle.
- R4: With sharing off, `tx_out_byte` equals the A byte one clock after each strobe, for every channel, whatever the B byte is.
- R5: With sharing on, an odd-channel receive strobe for channel 2j+1 produces, one clock later, `rx_out_valid`=1 with `rx_out_chan`=2j, `out_a_byte` equal to the byte last received on an even channel, and `out_b_byte` equal to the odd byte.
- R6: The clock after an R5 output, the block raises `rx_out_valid` again with `rx_out_chan`=2j+1 and the same two bytes.
- R7: With sharing on, an even-channel receive strobe produces no output strobe in the following cycle. It only stores the byte.
- R8: With sharing off, each receive strobe gives, one clock later, `rx_out_valid`=1, `rx_out_chan` equal to the input channel, `out_a_byte` equal to the fiber byte and `out_b_byte`=0.
- R9: `out_a_en` equals `link_sync` delayed by one clock. `out_b_en` equals `link_sync` AND `share_on`, also one clock later, so it is low whenever sharing is off or sync is lost.
- R10: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 3 | Mode code |
| link_sync | input | 1 | Receive link is in frame sync |
| tx_valid | input | 1 | Transmit channel strobe |
| tx_chan | input | 5 | Transmit channel index |
| tx_a_byte | input | 8 | Stream A byte for this channel |
| tx_b_byte | input | 8 | Stream B byte for this channel |
| tx_out_valid | output | 1 | Fiber byte strobe |
| tx_out_chan | output | 5 | Fiber channel index |
| tx_out_byte | output | 8 | Byte placed in the fiber slot |
| rx_valid | input | 1 | Receive fiber byte strobe |
| rx_chan | input | 5 | Receive fiber channel index |
| rx_byte | input | 8 | Received fiber byte |
| rx_out_valid | output | 1 | Output channel strobe |
| rx_out_chan | output | 5 | Output channel index |
| out_a_byte | output | 8 | Byte for output stream A |
| out_b_byte | output | 8 | Byte for output stream B |
| out_a_en | output | 1 | Output A drive enable |
| out_b_en | output | 1 | Output B drive enable |
| share_on | output | 1 | Sharing active |
| periph_mode | output | 1 | Peripheral timing selected |
| mode_err | output | 1 | Undefined mode code |

## Verification
The hardest case to reach is the self-timed second half of a receive pair. The odd-slot repeat appears on a clock with no input strobe, and it must carry the bytes captured one and two strobes earlier. The stimulus feeds even/odd pairs with an empty cycle after each odd strobe and checks both output slots. Each pair uses different byte values, so stale holding-register contents would show. A final case drops sync and switches to an undefined code in the middle of a run, to check that the enables and the fallback take effect.

// File: rtl/chan_pair_pkg.sv
package chan_pair_pkg;

  typedef struct packed {
    logic share;
    logic periph;
    logic bad;
  } mode_t;

  // Mode code to operating flags; undefined codes fall back to no sharing.
  function automatic mode_t decode_mode(input logic [2:0] code);
    mode_t m;
    case (code)
      3'b000:  m = '{share: 1'b1, periph: 1'b0, bad: 1'b0};
      3'b001:  m = '{share: 1'b1, periph: 1'b1, bad: 1'b0};
      3'b011:  m = '{share: 1'b0, periph: 1'b0, bad: 1'b0};
      3'b111:  m = '{share: 1'b0, periph: 1'b1, bad: 1'b0};
      default: m = '{share: 1'b0, periph: 1'b0, bad: 1'b1};
    endcase
    return m;
  endfunction

  // Transmit source choice: stream B only for odd channels while sharing.
  function automatic logic take_b(input logic share, input logic chan_lsb);
    return share & chan_lsb;
  endfunction

endpackage

// File: rtl/cpm_mode_reg.sv
module cpm_mode_reg
  import chan_pair_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode_sel,
  output mode_t      mode_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= decode_mode(mode_sel);
  end
endmodule

// File: rtl/cpm_tx_pick.sv
module cpm_tx_pick
  import chan_pair_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              share,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [BYTE_W-1:0] in_a,
  input  logic [BYTE_W-1:0] in_b,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [BYTE_W-1:0] out_byte
);
  logic use_b;
  assign use_b = take_b(share, in_chan[0]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_byte  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_chan <= in_chan;
        out_byte <= use_b ? in_b : in_a;
      end
    end
  end
endmodule

// File: rtl/cpm_rx_spread.sv
module cpm_rx_spread #(
  parameter int BYTE_W = 8,
  parameter int CH_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              share,
  input  logic              sync,
  input  logic              in_valid,
  input  logic [CH_W-1:0]   in_chan,
  input  logic [BYTE_W-1:0] in_byte,
  output logic              out_valid,
  output logic [CH_W-1:0]   out_chan,
  output logic [BYTE_W-1:0] out_a,
  output logic [BYTE_W-1:0] out_b,
  output logic              a_en,
  output logic              b_en,
  output logic              pend_q
);
  logic [BYTE_W-1:0] even_hold;
  logic              odd_in;
  logic [CH_W-1:0]   pair_base;

  assign odd_in    = in_chan[0];
  assign pair_base = {in_chan[CH_W-1:1], 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_chan  <= '0;
      out_a     <= '0;
      out_b     <= '0;
      even_hold <= '0;
      pend_q    <= 1'b0;
      a_en      <= 1'b0;
      b_en      <= 1'b0;
    end else begin
      a_en      <= sync;
      b_en      <= sync & share;
      out_valid <= 1'b0;
      if (pend_q) begin
        // second slot of the pair: repeat both bytes
        out_valid <= 1'b1;
        out_chan  <= out_chan + 1'b1;
        pend_q    <= 1'b0;
      end else if (in_valid) begin
        if (share) begin
          if (!odd_in) begin
            even_hold <= in_byte;
          end else begin
            out_valid <= 1'b1;
            out_chan  <= pair_base;
            out_a     <= even_hold;
            out_b     <= in_byte;
            pend_q    <= 1'b1;
          end
        end else begin
          out_valid <= 1'b1;
          out_chan  <= in_chan;
          out_a     <= in_byte;
          out_b     <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/chan_pair_mux.sv
module chan_pair_mux
  import chan_pair_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int CHANS  = 32,
  localparam int CH_W  = $clog2(CHANS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        mode_sel,
  input  logic              link_sync,
  input  logic              tx_valid,
  input  logic [CH_W-1:0]   tx_chan,
  input  logic [BYTE_W-1:0] tx_a_byte,
  input  logic [BYTE_W-1:0] tx_b_byte,
  output logic              tx_out_valid,
  output logic [CH_W-1:0]   tx_out_chan,
  output logic [BYTE_W-1:0] tx_out_byte,
  input  logic              rx_valid,
  input  logic [CH_W-1:0]   rx_chan,
  input  logic [BYTE_W-1:0] rx_byte,
  output logic              rx_out_valid,
  output logic [CH_W-1:0]   rx_out_chan,
  output logic [BYTE_W-1:0] out_a_byte,
  output logic [BYTE_W-1:0] out_b_byte,
  output logic              out_a_en,
  output logic              out_b_en,
  output logic              share_on,
  output logic              periph_mode,
  output logic              mode_err
);
  mode_t mode_q;
  logic  pend_w;

  cpm_mode_reg mode_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .mode_q(mode_q)
  );

  assign share_on    = mode_q.share;
  assign periph_mode = mode_q.periph;
  assign mode_err    = mode_q.bad;

  cpm_tx_pick #(.BYTE_W(BYTE_W), .CH_W(CH_W)) tx_i (
    .clk(clk), .rst_n(rst_n), .share(mode_q.share),
    .in_valid(tx_valid), .in_chan(tx_chan), .in_a(tx_a_byte), .in_b(tx_b_byte),
    .out_valid(tx_out_valid), .out_chan(tx_out_chan), .out_byte(tx_out_byte)
  );

  cpm_rx_spread #(.BYTE_W(BYTE_W), .CH_W(CH_W)) rx_i (
    .clk(clk), .rst_n(rst_n), .share(mode_q.share), .sync(link_sync),
    .in_valid(rx_valid), .in_chan(rx_chan), .in_byte(rx_byte),
    .out_valid(rx_out_valid), .out_chan(rx_out_chan),
    .out_a(out_a_byte), .out_b(out_b_byte),
    .a_en(out_a_en), .b_en(out_b_en), .pend_q(pend_w)
  );
endmodule

// File: rtl/chan_pair_mux_chk.sv
module chan_pair_mux_chk #(
  parameter int BYTE_W = 8,
  parameter int CH_W   = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        mode_sel,
  input logic              link_sync,
  input logic              tx_valid,
  input logic [CH_W-1:0]   tx_chan,
  input logic [BYTE_W-1:0] tx_a_byte,
  input logic [BYTE_W-1:0] tx_out_byte,
  input logic              rx_valid,
  input logic [CH_W-1:0]   rx_chan,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              rx_out_valid,
  input logic [CH_W-1:0]   rx_out_chan,
  input logic [BYTE_W-1:0] out_a_byte,
  input logic [BYTE_W-1:0] out_b_byte,
  input logic              out_a_en,
  input logic              out_b_en,
  input logic              share_on,
  input logic              periph_mode,
  input logic              mode_err,
  input logic              pend_w
);
  logic undef_code;
  assign undef_code = (mode_sel == 3'b010) || (mode_sel == 3'b100) ||
                      (mode_sel == 3'b101) || (mode_sel == 3'b110);

  // R2
  undef_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    undef_code |=> (mode_err && !share_on && !periph_mode));

  // R3
  tx_even_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && share_on && !tx_chan[0]) |=> (tx_out_byte == $past(tx_a_byte)));

  // R4
  tx_pass_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !share_on) |=> (tx_out_byte == $past(tx_a_byte)));

  // R6
  pair_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_w |=> (rx_out_valid && $stable(out_a_byte) && $stable(out_b_byte) &&
                rx_out_chan[0] && !rx_out_chan[0] == 1'b0));

  // R7
  even_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && share_on && !rx_chan[0] && !pend_w) |=> !rx_out_valid);

  // R8
  rx_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !share_on && !pend_w) |=>
      (rx_out_valid && out_a_byte == $past(rx_byte) &&
       rx_out_chan == $past(rx_chan) && out_b_byte == '0));

  // R9
  sync_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !link_sync |=> (!out_a_en && !out_b_en));

  // R9
  b_en_share_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !share_on |=> !out_b_en);
endmodule

bind chan_pair_mux chan_pair_mux_chk #(.BYTE_W(BYTE_W), .CH_W(CH_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .link_sync(link_sync),
  .tx_valid(tx_valid), .tx_chan(tx_chan), .tx_a_byte(tx_a_byte),
  .tx_out_byte(tx_out_byte), .rx_valid(rx_valid), .rx_chan(rx_chan),
  .rx_byte(rx_byte), .rx_out_valid(rx_out_valid), .rx_out_chan(rx_out_chan),
  .out_a_byte(out_a_byte), .out_b_byte(out_b_byte), .out_a_en(out_a_en),
  .out_b_en(out_b_en), .share_on(share_on), .periph_mode(periph_mode),
  .mode_err(mode_err), .pend_w(pend_w)
);

// File: tb/chan_pair_mux_tb_top.sv
module chan_pair_mux_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode_sel = 3'b000;
  logic       link_sync = 1'b0;
  logic       tx_valid = 1'b0;
  logic [4:0] tx_chan = '0;
  logic [7:0] tx_a_byte = '0, tx_b_byte = '0;
  logic       tx_out_valid;
  logic [4:0] tx_out_chan;
  logic [7:0] tx_out_byte;
  logic       rx_valid = 1'b0;
  logic [4:0] rx_chan = '0;
  logic [7:0] rx_byte = '0;
  logic       rx_out_valid;
  logic [4:0] rx_out_chan;
  logic [7:0] out_a_byte, out_b_byte;
  logic       out_a_en, out_b_en, share_on, periph_mode, mode_err;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  chan_pair_mux dut_i (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .link_sync(link_sync),
    .tx_valid(tx_valid), .tx_chan(tx_chan), .tx_a_byte(tx_a_byte),
    .tx_b_byte(tx_b_byte), .tx_out_valid(tx_out_valid),
    .tx_out_chan(tx_out_chan), .tx_out_byte(tx_out_byte),
    .rx_valid(rx_valid), .rx_chan(rx_chan), .rx_byte(rx_byte),
    .rx_out_valid(rx_out_valid), .rx_out_chan(rx_out_chan),
    .out_a_byte(out_a_byte), .out_b_byte(out_b_byte),
    .out_a_en(out_a_en), .out_b_en(out_b_en), .share_on(share_on),
    .periph_mode(periph_mode), .mode_err(mode_err)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", req, got, exp);
    end
  endtask

  // Drive at the falling edge, sample 1 ns after the next rising edge.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    mode_sel = m;
    step();
  endtask

  task automatic t_reset();
    step();
    // R10
    chk("R10 tx_out_byte", tx_out_byte, 0);
    chk("R10 tx_out_valid", tx_out_valid, 0);
    chk("R10 rx_out_valid", rx_out_valid, 0);
    chk("R10 out_a_en", out_a_en, 0);
    chk("R10 share_on", share_on, 0);
    chk("R10 mode_err", mode_err, 0);
  endtask

  task automatic t_modes();
    for (int c = 0; c < 8; c++) begin
      logic es, ep, ee;
      case (c)
        0: begin es = 1; ep = 0; ee = 0; end
        1: begin es = 1; ep = 1; ee = 0; end
        3: begin es = 0; ep = 0; ee = 0; end
        7: begin es = 0; ep = 1; ee = 0; end
        default: begin es = 0; ep = 0; ee = 1; end
      endcase
      set_mode(3'(c));
      // R1 for defined codes, R2 for undefined ones
      chk(ee ? "R2 share_on" : "R1 share_on", share_on, es);
      chk(ee ? "R2 periph_mode" : "R1 periph_mode", periph_mode, ep);
      chk(ee ? "R2 mode_err" : "R1 mode_err", mode_err, ee);
    end
  endtask

  task automatic t_tx(input logic share, input string req);
    for (int k = 0; k < 32; k++) begin
      logic [7:0] a, b;
      a = 8'(8'hA0 + k * 3);
      b = 8'(8'h51 ^ (k * 5));
      @(negedge clk);
      tx_valid = 1'b1; tx_chan = 5'(k); tx_a_byte = a; tx_b_byte = b;
      step();
      chk({req, " tx_out_byte"}, tx_out_byte, (share && k[0]) ? b : a);
      chk({req, " tx_out_chan"}, tx_out_chan, k);
      chk({req, " tx_out_valid"}, tx_out_valid, 1);
    end
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic t_rx_share();
    for (int j = 0; j < 16; j++) begin
      logic [7:0] ev, od;
      ev = 8'(j * 7 + 3);
      od = 8'(~(j * 11));
      @(negedge clk);
      rx_valid = 1'b1; rx_chan = 5'(2 * j); rx_byte = ev;
      step();
      chk("R7 even no strobe", rx_out_valid, 0);
      @(negedge clk);
      rx_chan = 5'(2 * j + 1); rx_byte = od;
      step();
      chk("R5 valid", rx_out_valid, 1);
      chk("R5 chan", rx_out_chan, 2 * j);
      chk("R5 out_a", out_a_byte, ev);
      chk("R5 out_b", out_b_byte, od);
      @(negedge clk);
      rx_valid = 1'b0; rx_byte = 8'hEE;
      step();
      chk("R6 valid", rx_out_valid, 1);
      chk("R6 chan", rx_out_chan, 2 * j + 1);
      chk("R6 out_a", out_a_byte, ev);
      chk("R6 out_b", out_b_byte, od);
      chk("R9 out_b_en share", out_b_en, 1);
    end
  endtask

  task automatic t_rx_plain();
    for (int k = 0; k < 32; k++) begin
      logic [7:0] v;
      v = 8'(8'h3C + k * 9);
      @(negedge clk);
      rx_valid = 1'b1; rx_chan = 5'(k); rx_byte = v;
      step();
      chk("R8 valid", rx_out_valid, 1);
      chk("R8 chan", rx_out_chan, k);
      chk("R8 out_a", out_a_byte, v);
      chk("R8 out_b", out_b_byte, 0);
    end
    @(negedge clk);
    rx_valid = 1'b0;
    step();
    chk("R9 out_b_en noshare", out_b_en, 0);
    chk("R9 out_a_en", out_a_en, 1);
  endtask

  task automatic t_sync_loss();
    @(negedge clk);
    link_sync = 1'b0;
    step();
    chk("R9 a_en lost", out_a_en, 0);
    chk("R9 b_en lost", out_b_en, 0);
    @(negedge clk);
    link_sync = 1'b1;
    step();
    chk("R9 a_en back", out_a_en, 1);
    chk("R9 b_en back", out_b_en, share_on);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    link_sync = 1'b1;
    t_modes();
    set_mode(3'b000);
    t_tx(1'b1, "R3");
    set_mode(3'b011);
    t_tx(1'b0, "R4");
    set_mode(3'b001);
    step();
    t_rx_share();
    t_sync_loss();
    set_mode(3'b111);
    step();
    t_rx_plain();
    set_mode(3'b101);
    // R2: undefined code falls back to pass-through of stream A
    t_tx(1'b0, "R2");
    t_sync_loss();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule